// File: doc/BRIEF.md
# Configuration Bitstream Loader

This peripheral feeds a configuration bitstream into a downstream programmable device. Software (or an external DMA engine) writes 32-bit words into a data port, where they wait in a FIFO. A sequencer takes each word and sends it out most-significant byte first, one byte per clock on a byte-wide configuration port. It counts every byte it sends against a total that software sets beforehand. When that total has been sent, or when an error appears, the sequencer stops and raises an interrupt. Software acknowledges the interrupt by writing the control register with the enable bit clear.

The sequencer has three states. `ST_IDLE` is the state after reset and after any control write that clears enable. `ST_RUN` moves bytes out. `ST_FIN` holds the interrupt. The transitions are as follows:
- `go`: `ST_IDLE` to `ST_RUN`, on a control write that sets enable while enable was clear.
- `finish`: `ST_RUN` to `ST_FIN`, when the byte count reaches the total or any error flag is set.
- `ack`: `ST_RUN` or `ST_FIN` to `ST_IDLE`, on a control write with enable clear.

Words may be loaded into the FIFO before the sequencer is enabled. Enabling the sequencer throws away any partly sent word that is still in the shifter.

Top module: `cfg_loader`

## Requirements
- R1: After reset, the outputs and registers are in their idle values: control reads 0, status reads 0 (with `cfg_done_i` low), FIFO fill reads 0, current count reads 0, and `irq`, `dma_req` and `cfg_rst` are low.
- R2: The FIFO size register (offset 0x48) reads the FIFO depth in bytes, which is 4 × `FIFO_DEPTH`.
- R3: The control register (offset 0x40) and the total byte count register (offset 0x50) read back the last value written to them. In the control register, bit 0 is enable, bit 1 is reset request, and bit 2 selects DMA feed.
- R4: `cfg_rst` is high exactly while the control register holds both enable and reset request. Writing zero afterwards ends the pulse.
- R5: Each word written to the data port (offset 0x3000) comes out on `cfg_data` most-significant byte first. Words leave in the order they were written, with one byte for each cycle in which `cfg_valid` is high.
- R6: The current byte count register (offset 0x54) goes up by one for each byte sent, and never goes past the total.
- R7: When the current count equals the total, the sequencer stops sending bytes, even if data is still waiting, and `irq` goes high. Status bit 16 mirrors `irq`.
- R8: A control write with bit 0 clear drops `irq` in the following cycle.
- R9: The FIFO fill register (offset 0x4C) reads in bytes: 4 bytes for each buffered word, plus the bytes of the current word not yet sent. It reads 0 only when all accepted data has been sent.
- R10: A data-port write while the FIFO is full is dropped, and sets status bit 1 (overflow).
- R11: A high on `cfg_err_i` sets status bit 2. Any set error bit in status bits 15..1 ends the run with `irq`.
- R12: Status bit 18 reflects `cfg_done_i`. Status bit 0 is high while the sequencer is running.
- R13: `dma_req` is high only when all of these hold: the sequencer is running, DMA feed is selected, and at least half the FIFO is free. A request therefore always has room for a burst of `FIFO_DEPTH/2` words.
- R14: A control write that sets enable while enable was clear clears the error bits and the current byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| cfg_data | output | 8 | Configuration byte |
| cfg_valid | output | 1 | `cfg_data` is sent this cycle |
| cfg_rst | output | 1 | Reset line to the configured device |
| cfg_done_i | input | 1 | Configuration done from the device |
| cfg_err_i | input | 1 | Error indication from the device |
| dma_req | output | 1 | Burst request to the DMA engine |
| irq | output | 1 | Completion or failure interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so control readback, `cfg_rst`, error clearing and `irq` acknowledge are all visible in the half cycle after that edge. Two edges then pass (one to enter `ST_RUN`, one to load the shifter) before the first byte appears. The interrupt follows one edge after the byte that reaches the total. Because byte timing depends on FIFO contents, the bench does not count cycles for byte order or for the interrupt. Instead it records every byte on the falling edges where `cfg_valid` is high, and waits for `irq` with a bounded loop. The DMA check relies on exact timing: right after the enabling edge the FIFO still holds nine words, so `dma_req` must be low; one pop later it must rise.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } seq_state_t;

    localparam logic [15:0] OFF_CTRL  = 16'h0040;
    localparam logic [15:0] OFF_STAT  = 16'h0044;
    localparam logic [15:0] OFF_SIZE  = 16'h0048;
    localparam logic [15:0] OFF_USED  = 16'h004C;
    localparam logic [15:0] OFF_TOTAL = 16'h0050;
    localparam logic [15:0] OFF_CUR   = 16'h0054;
    localparam logic [15:0] OFF_DATA  = 16'h3000;

    localparam int CTL_EN  = 0;
    localparam int CTL_RST = 1;
    localparam int CTL_DMA = 2;
endpackage

// File: rtl/cfgl_fifo.sv
module cfgl_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [CW-1:0] cnt,
    output logic          full,
    output logic          empty
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // R10
    fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (cnt == $past(cnt)));

    // R9
    fifo_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty && !push) |=> (cnt == '0));
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
    import cfgl_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] total,
    input  logic             fault,
    input  logic             fifo_empty,
    input  logic [31:0]      fifo_word,
    output logic             pop,
    output logic [7:0]       cfg_data,
    output logic             cfg_valid,
    output logic [CNT_W-1:0] cur_cnt,
    output logic [2:0]       sh_left,
    output logic             irq,
    output logic             running
);
    seq_state_t state, nstate;
    logic [31:0] sh_reg;
    logic        more;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (en_set) nstate = ST_RUN;
            ST_RUN: begin
                if (en_clr)                         nstate = ST_IDLE;
                else if (fault || cur_cnt >= total) nstate = ST_FIN;
            end
            ST_FIN:  if (en_clr) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    always_comb begin
        running   = (state == ST_RUN);
        irq       = (state == ST_FIN);
        more      = (cur_cnt < total);
        cfg_valid = running && more && (sh_left != 3'd0);
        cfg_data  = sh_reg[31:24];
        pop       = running && more && !fifo_empty &&
                    ((sh_left == 3'd0) || (sh_left == 3'd1 && cfg_valid));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_reg  <= '0;
            sh_left <= '0;
            cur_cnt <= '0;
        end else if (en_set) begin
            sh_left <= '0;
            cur_cnt <= '0;
        end else begin
            if (pop) begin
                sh_reg  <= fifo_word;
                sh_left <= 3'd4;
            end else if (cfg_valid) begin
                sh_reg  <= {sh_reg[23:0], 8'h00};
                sh_left <= sh_left - 3'd1;
            end
            if (cfg_valid) cur_cnt <= cur_cnt + 1'b1;
        end
    end

    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_valid && !en_set) |=> (cur_cnt == $past(cur_cnt) + 1'b1));

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && $stable(total)) |-> (cur_cnt <= total));

    // R8
    irq_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> !irq);

    // R7
    fin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> (!cfg_valid || en_set || $past(en_set)));
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
    import cfgl_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [15:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [7:0]  cfg_data,
    output logic        cfg_valid,
    output logic        cfg_rst,
    input  logic        cfg_done_i,
    input  logic        cfg_err_i,
    output logic        dma_req,
    output logic        irq
);
    localparam int FIFO_BYTES = FIFO_DEPTH * 4;
    localparam int HALF       = FIFO_DEPTH / 2;
    localparam int CW         = $clog2(FIFO_DEPTH) + 1;

    logic [2:0]       ctrl_q;
    logic [CNT_W-1:0] total_q;
    logic             ovf_err, dev_err;
    logic             ctrl_wr, en_set, en_clr, fifo_push, fifo_pop;
    logic [31:0]      fifo_word;
    logic [CW-1:0]    fifo_cnt;
    logic             fifo_full, fifo_empty, running;
    logic [CNT_W-1:0] cur_cnt;
    logic [2:0]       sh_left;
    logic [31:0]      used_bytes, status;

    assign ctrl_wr   = bus_wr && (bus_addr == OFF_CTRL);
    assign en_set    = ctrl_wr && bus_wdata[CTL_EN] && !ctrl_q[CTL_EN];
    assign en_clr    = ctrl_wr && !bus_wdata[CTL_EN];
    assign fifo_push = bus_wr && (bus_addr == OFF_DATA);

    cfgl_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(fifo_push), .pop(fifo_pop),
        .din(bus_wdata), .dout(fifo_word), .cnt(fifo_cnt),
        .full(fifo_full), .empty(fifo_empty)
    );

    cfgl_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .en_set(en_set), .en_clr(en_clr),
        .total(total_q), .fault(ovf_err || dev_err),
        .fifo_empty(fifo_empty), .fifo_word(fifo_word), .pop(fifo_pop),
        .cfg_data(cfg_data), .cfg_valid(cfg_valid), .cur_cnt(cur_cnt),
        .sh_left(sh_left), .irq(irq), .running(running)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            total_q <= '0;
            ovf_err <= 1'b0;
            dev_err <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl_q <= bus_wdata[2:0];
            if (bus_wr && bus_addr == OFF_TOTAL) total_q <= bus_wdata[CNT_W-1:0];
            if (en_set) begin
                ovf_err <= 1'b0;
                dev_err <= 1'b0;
            end else begin
                if (fifo_push && fifo_full) ovf_err <= 1'b1;
                if (cfg_err_i)              dev_err <= 1'b1;
            end
        end
    end

    always_comb begin
        cfg_rst    = ctrl_q[CTL_EN] && ctrl_q[CTL_RST];
        dma_req    = ctrl_q[CTL_DMA] && running &&
                     ((CW'(FIFO_DEPTH) - fifo_cnt) >= CW'(HALF));
        used_bytes = 32'(fifo_cnt) * 32'd4 + 32'(sh_left);
        status     = {13'd0, cfg_done_i, 1'b0, irq, 13'd0, dev_err, ovf_err, running};
        case (bus_addr)
            OFF_CTRL:  bus_rdata = {29'd0, ctrl_q};
            OFF_STAT:  bus_rdata = status;
            OFF_SIZE:  bus_rdata = 32'(FIFO_BYTES);
            OFF_USED:  bus_rdata = used_bytes;
            OFF_TOTAL: bus_rdata = 32'(total_q);
            OFF_CUR:   bus_rdata = 32'(cur_cnt);
            default:   bus_rdata = 32'd0;
        endcase
    end

    // R10
    ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_push && fifo_full) |=> ovf_err);

    // R4
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && bus_wdata[1:0] == 2'b11) |=> cfg_rst);

    // R13
    dma_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !bus_wdata[CTL_DMA]) |=> !dma_req);

    // R14
    err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> (!ovf_err && !dev_err && cur_cnt == '0));
endmodule

// File: tb/sim_cfg_loader.sv
`timescale 1ns/100ps
module sim_cfg_loader;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  cfg_data;
    logic        cfg_valid, cfg_rst, dma_req, irq;
    logic        cfg_done_i = 1'b0;
    logic        cfg_err_i = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    bit fin_flag = 0;
    logic [7:0] cap [256];
    int cap_n = 0;

    always #2.5 clk = ~clk;

    cfg_loader #(.FIFO_DEPTH(DEPTH), .CNT_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_data(cfg_data),
        .cfg_valid(cfg_valid), .cfg_rst(cfg_rst), .cfg_done_i(cfg_done_i),
        .cfg_err_i(cfg_err_i), .dma_req(dma_req), .irq(irq)
    );

    always @(negedge clk) begin
        if (rst_n && cfg_valid) begin
            if (cap_n < 256) cap[cap_n] = cfg_data;
            cap_n++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_irq(input int lim);
        for (int i = 0; i < lim; i++) begin
            if (irq) break;
            @(negedge clk);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [31:0] w, input int k);
        return w[8*(3-k) +: 8];
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(16'h0040, d); chk("R1 ctrl", d, 0);
        rd(16'h0044, d); chk("R1 status", d, 0);
        rd(16'h004C, d); chk("R1 used", d, 0);
        rd(16'h0054, d); chk("R1 cur", d, 0);
        chk("R1 pins", {irq, dma_req, cfg_rst}, 0);
        rd(16'h0048, d); chk("R2 size", d, DEPTH * 4);
    endtask

    task automatic t_ctrl();
        logic [31:0] d;
        wr(16'h0040, 32'h3);
        chk("R4 rst high", cfg_rst, 1);
        rd(16'h0040, d); chk("R3 ctrl rb", d, 3);
        wr(16'h0040, 32'h0);
        chk("R4 rst low", cfg_rst, 0);
        chk("R8 irq low", irq, 0);
        wr(16'h0050, 32'h0000_1234);
        rd(16'h0050, d); chk("R3 total rb", d, 32'h1234);
    endtask

    task automatic t_done();
        logic [31:0] d;
        cfg_done_i = 1'b1;
        rd(16'h0044, d); chk("R12 done", d[18], 1);
        cfg_done_i = 1'b0;
        rd(16'h0044, d); chk("R12 done low", d[18], 0);
    endtask

    task automatic t_cpu();
        logic [31:0] d;
        logic [31:0] w [3] = '{32'h11223344, 32'h55667788, 32'h99AABBCC};
        wr(16'h0050, 32'd10);
        for (int i = 0; i < 3; i++) wr(16'h3000, w[i]);
        rd(16'h004C, d); chk("R9 used preload", d, 12);
        cap_n = 0;
        wr(16'h0040, 32'h1);
        rd(16'h0044, d); chk("R12 running", d[0], 1);
        wait_irq(200);
        chk("R7 irq", irq, 1);
        chk("R5 byte count", cap_n, 10);
        for (int k = 0; k < 10; k++) chk("R5 byte order", cap[k], byte_of(w[k/4], k%4));
        rd(16'h0054, d); chk("R6 cur", d, 10);
        rd(16'h004C, d); chk("R9 used partial", d, 2);
        rd(16'h0044, d); chk("R7 status irq", d[16], 1);
        repeat (3) @(negedge clk);
        chk("R7 stopped", cap_n, 10);
        wr(16'h0040, 32'h0);
        chk("R8 irq ack", irq, 0);
    endtask

    task automatic t_used_zero();
        logic [31:0] d;
        wr(16'h0050, 32'd8);
        wr(16'h3000, 32'hA1B2C3D4);
        wr(16'h3000, 32'h0F1E2D3C);
        cap_n = 0;
        wr(16'h0040, 32'h1);
        wait_irq(200);
        rd(16'h004C, d); chk("R9 used zero", d, 0);
        rd(16'h0054, d); chk("R6 cur 8", d, 8);
        chk("R5 first", cap[0], 8'hA1);
        chk("R5 last", cap[7], 8'h3C);
        wr(16'h0040, 32'h0);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        for (int i = 0; i <= DEPTH; i++) wr(16'h3000, 32'h0101_0100 * (i + 1) + i);
        rd(16'h0044, d); chk("R10 ovf flag", d[1], 1);
        rd(16'h004C, d); chk("R10 used full", d, DEPTH * 4);
        wr(16'h0050, DEPTH * 4);
        cap_n = 0;
        wr(16'h0040, 32'h1);
        rd(16'h0044, d); chk("R14 err clr", d[15:1], 0);
        rd(16'h0054, d); chk("R14 cur clr", d, 0);
        wait_irq(500);
        rd(16'h0054, d); chk("R6 cur full", d, DEPTH * 4);
        chk("R10 bytes", cap_n, DEPTH * 4);
        chk("R10 last byte", cap[DEPTH*4-1], byte_of(32'h0101_0100 * DEPTH + (DEPTH - 1), 3));
        rd(16'h004C, d); chk("R10 dropped", d, 0);
        wr(16'h0040, 32'h0);
    endtask

    task automatic t_dma();
        wr(16'h0040, 32'h4);
        chk("R13 idle no req", dma_req, 0);
        for (int i = 0; i < DEPTH/2 + 1; i++) wr(16'h3000, 32'hC0DE_0000 + i);
        wr(16'h0050, 32'd1000);
        wr(16'h0040, 32'h5);
        chk("R13 req low full", dma_req, 0);
        for (int i = 0; i < 20; i++) begin
            if (dma_req) break;
            @(negedge clk);
        end
        chk("R13 req high", dma_req, 1);
        wr(16'h0040, 32'h1);
        chk("R13 cpu no req", dma_req, 0);
        wr(16'h0040, 32'h0);
    endtask

    task automatic t_err();
        logic [31:0] d;
        wr(16'h0050, 32'd100);
        wr(16'h3000, 32'hDEADBEEF);
        wr(16'h0040, 32'h1);
        @(negedge clk);
        cfg_err_i = 1'b1;
        @(negedge clk);
        cfg_err_i = 1'b0;
        wait_irq(20);
        chk("R11 irq", irq, 1);
        rd(16'h0044, d); chk("R11 dev err", d[2], 1);
        wr(16'h0040, 32'h0);
        chk("R8 irq ack err", irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_done();
        t_cpu();
        t_used_zero();
        t_overflow();
        t_dma();
        t_err();
        if (!fin_flag) begin
            fin_flag = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!fin_flag) begin
            fin_flag = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule